// File: doc/BRIEF.md
# Upper-Memory Shadow Attribute Decoder

This block keeps seven byte-wide attribute registers that a host programs through a plain register write and read port. For every memory request that falls in the upper legacy window (0xC0000 to 0xFFFFF), it reports whether that read or write is served by internal DRAM or passed to the external bus. Firmware uses it to copy expansion and system ROM images into RAM and then run them from RAM.

Six of the registers each cover a 32 KB expansion-ROM slice made of two 16 KB halves. Each half has its own read enable and its own write enable. The seventh register covers the single 64 KB system ROM area at the top of the window. The route output is combinational in the request address and the access type. Register writes take effect at the next clock edge.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After a synchronous active-low reset, every attribute register reads back 0x00. Every read or write request inside 0xC0000–0xFFFFF then reports route_int = 0 (external).
- R2: A request whose address lies outside 0xC0000–0xFFFFF always gives route_int = 1, whatever the registers hold.
- R3: The register at offset 0x70+i (i = 0..5) governs a lower half starting at 0xC0000 + 0x8000·i and an upper half starting 0x4000 above it. Request address bit 14 picks the half.
- R4: In the registers at 0x70–0x75, bit 3 enables internal reads of the lower half and bit 1 enables internal writes of it. Bit 7 does the same for reads of the upper half, and bit 5 for its writes.
- R5: The register at offset 0x76 governs 0xF0000–0xFFFFF. Its bit 7 enables internal reads and its bit 5 enables internal writes.
- R6: When the enable bit for the request's type is clear, route_int is 0 (external bus). req_write = 1 marks a write and 0 marks a read.
- R7: A write to offsets 0x70–0x75 stores the data ANDed with 0xEE, and reading the register back returns that masked value.
- R8: A write to offset 0x76 stores the data ANDed with 0xE8, and reading it back returns that masked value.
- R9: Reading any offset other than 0x70–0x76 returns 0x00. A write to such an offset changes no register and no routing decision.
- R10: A register write becomes visible on cfg_rdata and route_int from the clock edge that captures it. A request in the same cycle as the write sees the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Masked stored value at cfg_addr |
| req_addr | input | 20 | Memory request address |
| req_write | input | 1 | Request type: 1 write, 0 read |
| route_int | output | 1 | 1 = internal DRAM, 0 = external bus |

## Verification
A register update and a route lookup in the same segment can fall in the same cycle. In that case the lookup must use the setting from before the update. The bench provokes this by holding a read request on 0xC0000 while it writes 0x70 with the lower-read enable set. It expects route_int = 0 just before the capturing edge and 1 just after it. A reset that arrives while registers hold live settings is judged the same way: readback and route must both fall back at the next edge.

// File: rtl/shadow_pkg.sv
// Shared constants for the upper-memory shadow attribute decoder.
// Assumes a 20-bit real-mode address and 8-bit register offsets.
package shadow_pkg;
    typedef logic [7:0] attr_byte_t;

    localparam logic [7:0] ATTR_BASE  = 8'h70;  // first attribute offset
    localparam int         PAIR_COUNT = 6;      // 32 KB expansion slices
    localparam int         ATTR_REGS  = PAIR_COUNT + 1;
    localparam attr_byte_t PAIR_WMASK = 8'hEE;
    localparam attr_byte_t SYS_WMASK  = 8'hE8;

    // enable bit positions inside an attribute byte
    localparam int LO_RD_BIT  = 3;
    localparam int LO_WR_BIT  = 1;
    localparam int HI_RD_BIT  = 7;
    localparam int HI_WR_BIT  = 5;
    localparam int SYS_RD_BIT = 7;
    localparam int SYS_WR_BIT = 5;

    // address decode: 32 KB slice index and 16 KB half select
    localparam int SLICE_LSB = 15;
    localparam int HALF_BIT  = 14;
endpackage

// File: rtl/shadow_attr_bank.sv
// Attribute register bank. Each register stores its write data ANDed with
// its own mask; the last register is the system-ROM one and uses a stricter
// mask. Readback is combinational; unmapped offsets read as zero.
// Assumes a synchronous active-low reset.
module shadow_attr_bank
    import shadow_pkg::*;
#(
    parameter int              NUM_REGS = ATTR_REGS,
    parameter int              RA_W     = 8,
    parameter logic [RA_W-1:0] BASE     = ATTR_BASE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [RA_W-1:0]              addr,
    input  logic [7:0]                   wdata,
    output logic [7:0]                   rdata,
    output logic [NUM_REGS-1:0][7:0]     attr
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [RA_W-1:0] MY_OFF  = BASE + RA_W'(g);
        localparam attr_byte_t      MY_MASK = (g == NUM_REGS - 1) ? SYS_WMASK : PAIR_WMASK;
        attr_byte_t q;

        // capture masked write data when this offset is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && (addr == MY_OFF))
                q <= wdata & MY_MASK;
        end

        assign attr[g] = q;
    end

    // select the addressed register for readback, zero when unmapped
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == BASE + RA_W'(i))
                rdata = attr[i];
        end
    end
endmodule

// File: rtl/shadow_route_lookup.sv
// Combinational route decision. Requests outside the top 256 KB window are
// reported internal. Inside it, the last register covers the top 64 KB and
// the others each cover a 32 KB slice split into two 16 KB halves.
// Assumes ADDR_W = 20 (bits 19:18 pick the window, bits 17:16 the top 64 KB).
module shadow_route_lookup
    import shadow_pkg::*;
#(
    parameter int NUM_REGS = ATTR_REGS,
    parameter int ADDR_W   = 20
) (
    input  logic [NUM_REGS-1:0][7:0] attr,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    output logic                     route_int
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             in_window;
    logic             in_sys;
    logic             upper_half;
    logic [IDX_W-1:0] slice;
    attr_byte_t       sel;

    assign in_window  = (req_addr[ADDR_W-1 -: 2] == 2'b11);
    assign in_sys     = in_window && (req_addr[ADDR_W-3 -: 2] == 2'b11);
    assign upper_half = req_addr[HALF_BIT];
    assign slice      = req_addr[SLICE_LSB +: IDX_W];

    // pick the governing byte and the enable bit for this access type
    always_comb begin
        sel       = '0;
        route_int = 1'b1;
        if (in_sys) begin
            sel       = attr[NUM_REGS-1];
            route_int = req_write ? sel[SYS_WR_BIT] : sel[SYS_RD_BIT];
        end else if (in_window) begin
            sel = attr[slice];
            if (upper_half)
                route_int = req_write ? sel[HI_WR_BIT] : sel[HI_RD_BIT];
            else
                route_int = req_write ? sel[LO_WR_BIT] : sel[LO_RD_BIT];
        end
    end
endmodule

// File: rtl/shadow_attr_decoder.sv
// Top of the upper-memory shadow attribute decoder: register bank plus
// combinational route lookup. Writes land at the clock edge; the route
// output follows the stored bank and the live request.
module shadow_attr_decoder
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int RA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RA_W-1:0]   cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              route_int
);
    logic [ATTR_REGS-1:0][7:0] attr;

    shadow_attr_bank #(
        .NUM_REGS (ATTR_REGS),
        .RA_W     (RA_W),
        .BASE     (RA_W'(ATTR_BASE))
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .attr  (attr)
    );

    shadow_route_lookup #(
        .NUM_REGS (ATTR_REGS),
        .ADDR_W   (ADDR_W)
    ) u_lookup (
        .attr      (attr),
        .req_addr  (req_addr),
        .req_write (req_write),
        .route_int (route_int)
    );
endmodule

// File: rtl/shadow_attr_chk.sv
// Port-level checker for shadow_attr_decoder, attached by bind.
module shadow_attr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic [19:0] req_addr,
    input logic        req_write,
    input logic        route_int
);
    logic in_win;
    logic pair_off;
    assign in_win   = (req_addr[19:18] == 2'b11);
    assign pair_off = (cfg_addr >= 8'h70) && (cfg_addr <= 8'h75);

    // R1: registers come out of reset cleared, window routed external
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == 8'h00) && (!in_win || !route_int));

    // R2: outside the window the route is always internal
    a_r2_outside_internal: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> route_int);

    // R7: slice registers keep only the 0xEE bits
    a_r7_pair_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && pair_off) |=>
        ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == ($past(cfg_wdata) & 8'hEE))));

    // R8: system register keeps only the 0xE8 bits
    a_r8_sys_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h76) |=>
        ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == ($past(cfg_wdata) & 8'hE8))));

    // R9: unmapped offsets read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_addr < 8'h70) || (cfg_addr > 8'h76)) |-> (cfg_rdata == 8'h00));
endmodule

bind shadow_attr_decoder shadow_attr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_addr  (req_addr),
    .req_write (req_write),
    .route_int (route_int)
);

// File: tb/tb_shadow_attr_decoder.sv
`timescale 1ns/1ps
module tb_shadow_attr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [19:0] req_addr = 20'h00000;
    logic        req_write = 1'b0;
    logic        route_int;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    shadow_attr_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .req_write(req_write), .route_int(route_int)
    );

    // {req tag, offset, data, probe address, probe is write, expected route}
    localparam int NV = 15;
    localparam logic [41:0] VEC [NV] = '{
        {4'd4, 8'h70, 8'h08, 20'hC0000, 1'b0, 1'b1},
        {4'd6, 8'h70, 8'h08, 20'hC0000, 1'b1, 1'b0},
        {4'd4, 8'h70, 8'h02, 20'hC3FFF, 1'b1, 1'b1},
        {4'd3, 8'h70, 8'h02, 20'hC4000, 1'b1, 1'b0},
        {4'd3, 8'h70, 8'h80, 20'hC4000, 1'b0, 1'b1},
        {4'd3, 8'h70, 8'h80, 20'hC0000, 1'b0, 1'b0},
        {4'd3, 8'h73, 8'h20, 20'hDC000, 1'b1, 1'b1},
        {4'd3, 8'h73, 8'h20, 20'hD9000, 1'b1, 1'b0},
        {4'd3, 8'h75, 8'hA0, 20'hEFFFF, 1'b0, 1'b1},
        {4'd3, 8'h75, 8'hA0, 20'hE8000, 1'b0, 1'b0},
        {4'd5, 8'h76, 8'h80, 20'hF0000, 1'b0, 1'b1},
        {4'd5, 8'h76, 8'h80, 20'hFFFFF, 1'b1, 1'b0},
        {4'd5, 8'h76, 8'h20, 20'hF8000, 1'b1, 1'b1},
        {4'd7, 8'h72, 8'h11, 20'hD0000, 1'b0, 1'b0},
        {4'd8, 8'h76, 8'h1F, 20'hF0000, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [19:0] a, input logic w);
        req_addr = a; req_write = w;
        #0.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and of in-window routing
        for (int i = 0; i < 7; i++) begin
            cfg_addr = 8'h70 + 8'(i); #0.5;
            chk("R1 readback after reset", cfg_rdata, 8'h00);
        end
        probe(20'hC0000, 1'b0); chk("R1 route C0000 read", route_int, 1'b0);
        probe(20'hF0000, 1'b1); chk("R1 route F0000 write", route_int, 1'b0);

        // table walk covering R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [7:0] off, data, mask;
            off  = VEC[v][37:30];
            data = VEC[v][29:22];
            mask = (off == 8'h76) ? 8'hE8 : 8'hEE;
            wr(off, data);
            cfg_addr = off;
            probe(VEC[v][21:2], VEC[v][1]);
            chk($sformatf("R%0d vector %0d route", VEC[v][41:38], v), route_int, VEC[v][0]);
            chk($sformatf("R%0d vector %0d readback", (off == 8'h76) ? 8 : 7, v), cfg_rdata, data & mask);
        end

        // R2: outside the window always internal, even with registers cleared
        wr(8'h70, 8'h00);
        probe(20'h00000, 1'b1); chk("R2 route 00000 write", route_int, 1'b1);
        probe(20'hBFFFF, 1'b0); chk("R2 route BFFFF read", route_int, 1'b1);
        probe(20'hA0000, 1'b1); chk("R2 route A0000 write", route_int, 1'b1);

        // R9: unmapped offsets read zero and leave routing alone
        wr(8'h77, 8'hFF);
        wr(8'h6F, 8'hFF);
        cfg_addr = 8'h77; #0.5; chk("R9 readback 77", cfg_rdata, 8'h00);
        cfg_addr = 8'h6F; #0.5; chk("R9 readback 6F", cfg_rdata, 8'h00);
        cfg_addr = 8'h70; #0.5; chk("R9 reg 70 untouched", cfg_rdata, 8'h00);
        probe(20'hC0000, 1'b0); chk("R9 route C0000 untouched", route_int, 1'b0);

        // R10: write and lookup in the same cycle, old value before the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h70; cfg_wdata = 8'h08;
        probe(20'hC0000, 1'b0);
        chk("R10 route before capture", route_int, 1'b0);
        @(posedge clk); #0.5;
        chk("R10 route after capture", route_int, 1'b1);
        @(negedge clk); cfg_we = 1'b0;

        // R1: reset with live settings clears readback and routing
        wr(8'h76, 8'hA0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cfg_addr = 8'h76; #0.5; chk("R1 sys reg after mid reset", cfg_rdata, 8'h00);
        probe(20'hC0000, 1'b0); chk("R1 route after mid reset", route_int, 1'b0);
        probe(20'hF0000, 1'b0); chk("R1 sys route after mid reset", route_int, 1'b0);

        finish_run();
    end
endmodule